// File: doc/BRIEF.md
# Multi-Pointer Traceback Survivor Memory

This block is the survivor store and bit recovery stage of a hard- or soft-decision trellis decoder with 2^V states and one input bit per trellis step. Each accepted step delivers one column of decision bits, one per state, together with the index of the state that currently holds the best path metric. The columns go into a circular store that is split into 2·K2 banks of C = T/(K2−1) columns each.

Each time a bank is filled, a new read pointer is launched from the supplied best state. The pointer walks back T columns to let the survivor paths merge, then continues through one more bank, yielding that bank's decoded bits newest-first. K2 pointers run at once, staggered by one bank, and each makes one read per accepted column. Because of this, writes only reach columns that have already been decoded. A pair of ping-pong stacks reverses every decoded bank, so the bits leave in time order with a valid strobe. Every stage advances only when an input column is accepted, so the upstream add-compare-select logic may stall freely.

Top module: `survivor_traceback`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld` is low and `out_bit` is 0 until the latency of R6 has elapsed.
- R2: Bit s of `col_dec` is the survivor decision of state s. During a walk back, the predecessor of state `cur` is `{cur[V-2:0], d}`, where d is the decision stored for `cur`. The decoded bit for a step is `cur[V-1]`, the MSB of the state that the step entered.
- R3: A new walk starts only on an accepted column whose zero-based step index modulo C equals C−1. It starts from the `best_state` presented with that column.
- R4: Each walk skips T columns, starting with the column that launched it, before it emits any decoded bit. It then emits exactly C bits. At most one walk emits bits in any cycle.
- R5: Decoded bits come out oldest step first, beginning with step 0, with no gap or repeat, including across many wraps of the circular store.
- R6: The bit of step i is presented, with `out_vld` high for one cycle, right after the (i + 2(T+C) + 1)-th accepted column. No bit is presented earlier, and from then on every accepted column yields one bit.
- R7: A cycle with `col_vld` low changes nothing: `out_vld` is low in the next cycle and `out_bit` holds. Values on `col_dec` and `best_state` in such a cycle are ignored.
- R8: Decisions stored in rows that are off the surviving path do not affect the decoded bits.
- R9: `best_state` on accepted columns that do not end a bank is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_vld | input | 1 | Accept this step's decision column |
| col_dec | input | 2^V | Survivor decision bit of each state |
| best_state | input | V | State with the best path metric after this step |
| out_vld | output | 1 | Decoded bit valid strobe |
| out_bit | output | 1 | Decoded bit, time order |

## Verification
A wrong pointer state, such as a bad column address, a wrong state update or a wrong phase, shows as wrong bits in the output stream. These bits appear at most 2(T+C)+1 accepted columns after the step concerned. A wrong swap or drain in the reversal stacks shows as reversed bit order within a bank, or as a missing or extra strobe. Either one is seen within C accepted columns of the bank boundary. A stall bug shows in the very next cycle as a spurious strobe or a changed output bit.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TRACE  = 2'd1,
    PH_DECODE = 2'd2
  } ptr_phase_e;
endpackage

// File: rtl/stb_pointer.sv
module stb_pointer #(
  parameter int V    = 2,
  parameter int T    = 8,
  parameter int C    = 4,
  parameter int COLS = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic                              start,
  input  logic [$clog2(COLS)-1:0]           start_col,
  input  logic [V-1:0]                      start_state,
  input  logic                              start_ok,
  output logic [$clog2(COLS)-1:0]           rd_col,
  input  logic [(1<<V)-1:0]                 rd_data,
  output logic                              bit_vld,
  output logic                              bit_val,
  output logic [((C>1)?$clog2(C):1)-1:0]    bit_idx,
  output logic                              done
);
  import stb_pkg::*;
  localparam int AW    = $clog2(COLS);
  localparam int DEPTH = T + C;
  localparam int CW    = $clog2(DEPTH);
  localparam int IW    = (C > 1) ? $clog2(C) : 1;

  ptr_phase_e     phase, phase_n;
  logic [AW-1:0]  col, col_n;
  logic [V-1:0]   state, state_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic           ok, ok_n;
  logic [V-1:0]   pred;
  logic [CW-1:0]  rel;

  // predecessor: shift the state one place up, decision fills the LSB
  assign pred    = {state[V-2:0], rd_data[state]};
  assign rd_col  = col;
  assign rel     = cnt - CW'(T);
  assign bit_idx = rel[IW-1:0];
  assign bit_val = state[V-1];
  assign bit_vld = adv && ok && (phase == PH_DECODE);
  assign done    = bit_vld && (cnt == CW'(DEPTH - 1));

  always_comb begin
    phase_n = phase;
    col_n   = col;
    state_n = state;
    cnt_n   = cnt;
    ok_n    = ok;
    if (phase != PH_IDLE) begin
      col_n   = (col == '0) ? AW'(COLS - 1) : col - 1'b1;
      state_n = pred;
      cnt_n   = cnt + 1'b1;
      if (cnt == CW'(T - 1))     phase_n = PH_DECODE;
      if (cnt == CW'(DEPTH - 1)) phase_n = PH_IDLE;
    end
    if (start) begin
      phase_n = PH_TRACE;
      col_n   = start_col;
      state_n = start_state;
      cnt_n   = '0;
      ok_n    = start_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      col   <= '0;
      state <= '0;
      cnt   <= '0;
      ok    <= 1'b0;
    end else if (adv) begin
      phase <= phase_n;
      col   <= col_n;
      state <= state_n;
      cnt   <= cnt_n;
      ok    <= ok_n;
    end
  end
endmodule

// File: rtl/stb_lifo2.sv
module stb_lifo2 #(
  parameter int C = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv,
  input  logic                            push,
  input  logic [((C>1)?$clog2(C):1)-1:0]  push_idx,
  input  logic                            push_bit,
  input  logic                            swap,
  output logic                            out_vld,
  output logic                            out_bit
);
  localparam int IW = (C > 1) ? $clog2(C) : 1;

  logic [C-1:0]  stk [2];
  logic          fill_sel, fill_n;
  logic          draining, drain_n;
  logic [IW-1:0] dcnt, dcnt_n;
  logic          vld_n, bit_n;

  always_ff @(posedge clk) begin
    if (adv && push) stk[fill_sel][push_idx] <= push_bit;
  end

  always_comb begin
    fill_n  = fill_sel;
    drain_n = draining;
    dcnt_n  = dcnt;
    vld_n   = 1'b0;
    bit_n   = out_bit;
    if (draining) begin
      vld_n = 1'b1;
      bit_n = stk[~fill_sel][dcnt];
      if (dcnt == '0) drain_n = 1'b0;
      else            dcnt_n  = dcnt - 1'b1;
    end
    if (swap) begin
      fill_n  = ~fill_sel;
      drain_n = 1'b1;
      dcnt_n  = IW'(C - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_sel <= 1'b0;
      draining <= 1'b0;
      dcnt     <= '0;
      out_bit  <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= adv & vld_n;
      if (adv) begin
        fill_sel <= fill_n;
        draining <= drain_n;
        dcnt     <= dcnt_n;
        out_bit  <= bit_n;
      end
    end
  end
endmodule

// File: rtl/survivor_traceback.sv
module survivor_traceback #(
  parameter int V  = 2,
  parameter int T  = 8,
  parameter int K2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_vld,
  input  logic [(1<<V)-1:0] col_dec,
  input  logic [V-1:0]     best_state,
  output logic             out_vld,
  output logic             out_bit
);
  localparam int N     = 1 << V;
  localparam int C     = T / (K2 - 1);
  localparam int NB    = 2 * K2;
  localparam int COLS  = NB * C;
  localparam int AW    = $clog2(COLS);
  localparam int DEPTH = T + C;
  localparam int SW    = $clog2(DEPTH);
  localparam int IW    = (C > 1) ? $clog2(C) : 1;
  localparam int PW    = (K2 > 1) ? $clog2(K2) : 1;

  logic [N-1:0]  mem [COLS];
  logic [AW-1:0] wcol, wcol_n;
  logic [IW-1:0] cpos, cpos_n;
  logic [SW-1:0] seen, seen_n;
  logic [PW-1:0] psel, psel_n;
  logic          bank_end;

  logic [AW-1:0] ptr_col  [K2];
  logic [N-1:0]  ptr_data [K2];
  logic [K2-1:0] ptr_bit_vld, ptr_bit_val, ptr_done, ptr_start;
  logic [IW-1:0] ptr_idx  [K2];

  logic          push, push_bit, swap;
  logic [IW-1:0] push_idx;

  always_ff @(posedge clk) begin
    if (col_vld) mem[wcol] <= col_dec;
  end

  assign bank_end = (cpos == IW'(C - 1));

  always_comb begin
    wcol_n = (wcol == AW'(COLS - 1)) ? '0 : wcol + 1'b1;
    cpos_n = bank_end ? '0 : cpos + 1'b1;
    seen_n = (seen == SW'(DEPTH - 1)) ? seen : seen + 1'b1;
    psel_n = psel;
    if (bank_end) psel_n = (psel == PW'(K2 - 1)) ? '0 : psel + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcol <= '0;
      cpos <= '0;
      seen <= '0;
      psel <= '0;
    end else if (col_vld) begin
      wcol <= wcol_n;
      cpos <= cpos_n;
      seen <= seen_n;
      psel <= psel_n;
    end
  end

  for (genvar p = 0; p < K2; p++) begin : g_ptr
    assign ptr_start[p] = col_vld && bank_end && (psel == PW'(p));
    assign ptr_data[p]  = mem[ptr_col[p]];
    stb_pointer #(.V(V), .T(T), .C(C), .COLS(COLS)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (col_vld),
      .start       (ptr_start[p]),
      .start_col   (wcol),
      .start_state (best_state),
      .start_ok    (seen == SW'(DEPTH - 1)),
      .rd_col      (ptr_col[p]),
      .rd_data     (ptr_data[p]),
      .bit_vld     (ptr_bit_vld[p]),
      .bit_val     (ptr_bit_val[p]),
      .bit_idx     (ptr_idx[p]),
      .done        (ptr_done[p])
    );
  end

  always_comb begin
    push_idx = '0;
    push_bit = 1'b0;
    for (int p = 0; p < K2; p++) begin
      if (ptr_bit_vld[p]) begin
        push_idx = ptr_idx[p];
        push_bit = ptr_bit_val[p];
      end
    end
  end

  assign push = |ptr_bit_vld;
  assign swap = |ptr_done;

  stb_lifo2 #(.C(C)) u_rev (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (col_vld),
    .push     (push),
    .push_idx (push_idx),
    .push_bit (push_bit),
    .swap     (swap),
    .out_vld  (out_vld),
    .out_bit  (out_bit)
  );
endmodule

// File: rtl/stb_checker.sv
module stb_checker #(
  parameter int V  = 2,
  parameter int T  = 8,
  parameter int K2 = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          col_vld,
  input logic          out_vld,
  input logic          out_bit,
  input logic [K2-1:0] dec_act
);
  localparam int C   = T / (K2 - 1);
  localparam int LAT = 2 * (T + C) + 1;
  localparam int W   = $clog2(LAT + 1);

  logic [W-1:0] nacc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               nacc <= '0;
    else if (col_vld && (nacc != W'(LAT)))   nacc <= nacc + 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!out_vld);
  end

  assert_no_early_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (nacc >= W'(LAT)));

  assert_steady_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && (nacc >= W'(LAT - 1))) |=> out_vld);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !col_vld |=> (!out_vld && $stable(out_bit)));

  assert_single_decoder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_act));
endmodule

bind survivor_traceback stb_checker #(.V(V), .T(T), .K2(K2)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .col_vld (col_vld),
  .out_vld (out_vld),
  .out_bit (out_bit),
  .dec_act (ptr_bit_vld)
);

// File: tb/sim_survivor_traceback.sv
module sim_survivor_traceback;
  localparam int V   = 2;
  localparam int T   = 8;
  localparam int K2  = 3;
  localparam int N   = 1 << V;
  localparam int C   = T / (K2 - 1);
  localparam int LAT = 2 * (T + C) + 1;
  localparam int NST = 260;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         col_vld;
  logic [N-1:0] col_dec;
  logic [V-1:0] best_state;
  logic         out_vld, out_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  survivor_traceback #(.V(V), .T(T), .K2(K2)) u0 (
    .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .col_dec(col_dec),
    .best_state(best_state), .out_vld(out_vld), .out_bit(out_bit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s);
    if (s < 80)  return "R2 R4 R5 R8";
    if (s < 160) return "R3 R9";
    return "R5 R7";
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit           u [NST];
    logic [V-1:0] st, nx;
    int           i, emitted, exp_idx;
    bit           exp_vld, exp_bit, stall;

    rst_n = 1'b0; col_vld = 1'b0; col_dec = '0; best_state = '0;
    st = '0; i = 0; emitted = 0; exp_vld = 0; exp_bit = 0; exp_idx = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R1 reset vld", out_vld, 0);
      chk(out_bit == 1'b0, "R1 reset bit", out_bit, 0);
    end
    rst_n = 1'b1;

    while (i < NST) begin
      @(negedge clk);
      // compare against the model's view of the last edge
      chk(out_vld == exp_vld, exp_vld ? "R6 strobe" : "R6 R7 no strobe", out_vld, exp_vld);
      chk(out_bit == exp_bit, exp_vld ? tag_of(exp_idx) : "R1 R7 hold", out_bit, exp_bit);
      if (out_vld) emitted++;

      stall = (i >= 160) && ($urandom_range(0, 2) == 0);
      if (stall) begin
        col_vld    = 1'b0;
        col_dec    = N'($urandom);
        best_state = V'($urandom);
        exp_vld    = 0;
      end else begin
        u[i] = 1'($urandom);
        nx   = {u[i], st[V-1:1]};
        col_dec     = N'($urandom);
        col_dec[nx] = st[0];
        if ((i % C == C - 1) || (i < 80)) best_state = nx;
        else                              best_state = V'($urandom);
        col_vld = 1'b1;
        st = nx;
        i++;
        if (i >= LAT) begin
          exp_vld = 1;
          exp_idx = i - LAT;
          exp_bit = u[exp_idx];
        end else begin
          exp_vld = 0;
        end
      end
    end
    @(negedge clk);
    chk(out_vld == exp_vld, "R6 strobe", out_vld, exp_vld);
    chk(out_bit == exp_bit, tag_of(exp_idx), out_bit, exp_bit);
    if (out_vld) emitted++;
    col_vld = 1'b0;
    @(negedge clk);
    chk(out_vld == 1'b0, "R7 idle", out_vld, 0);
    chk(out_bit == exp_bit, "R7 idle hold", out_bit, exp_bit);
    chk(emitted == NST - LAT + 1, "R6 bit count", emitted, NST - LAT + 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule